// File: doc/BRIEF.md
# Interrupt Broadcast Write Generator

This block turns an interrupt raised inside an I/O port into a single CSR write on the system bus. When a request with a priority level is accepted, the block takes the CPU destination mask held in its local mask register and packs the mask and the level into one data word. It then asks for the bus, waits for the grant, and drives the address and the packed word during the first data cycle of the write. There are no dedicated interrupt wires: every processor sees the broadcast write and decides from the mask whether it is a target.

The write lands in broadcast space, in the interrupt register that belongs to the sending module. That register is selected by the module's node number: the address is a fixed base plus the node number times a 64-byte stride, so node 4 writes the fifth register of the array. Requests that arrive while a write is under way are folded into a single pending entry that keeps the highest level seen, and that entry goes out right after the current write. If the mask register is all zero when a request is taken, no write is issued and a one-cycle status pulse is raised.

Top module: `intr_bcast_writer`

## Requirements
- R1: After reset `bus_req_o`, `csr_valid_o` and `drop_o` are 0 and the stored mask is 0, so the first request after reset is dropped unless the mask has been written.
- R2: A request taken with a nonzero mask while idle raises `bus_req_o` in the next cycle, and `bus_req_o` stays high until `bus_gnt_i` is sampled high.
- R3: `csr_valid_o` is high for exactly one cycle, the cycle after the grant is sampled with `bus_req_o` high; `bus_req_o` is low in that cycle.
- R4: The write data holds the CPU mask in bits 15:0 and the level in bits 20:16, all other bits 0; the mask is the register value at the moment the request is taken, so later mask writes do not alter a write already formed.
- R5: The write address is `BASE_ADDR + node_id_i * 64`.
- R6: `csr_addr_o` and `csr_data_o` are 0 in every cycle where `csr_valid_o` is low.
- R7: A request that arrives while a write is in progress is held and raises `bus_req_o` in the cycle right after the `csr_valid_o` cycle of the current write.
- R8: Several requests arriving while a write is in progress produce one further write, carrying the highest of their levels.
- R9: A request taken while the mask is all zero issues no bus request, pulses `drop_o` high for one cycle in the next cycle, and discards the request.
- R10: `bus_gnt_i` has no effect while `bus_req_o` is low.
- R11: A mask write in the same cycle as an accepted request does not affect that request's data; it applies to requests taken in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_valid_i | input | 1 | Interrupt request strobe |
| irq_level_i | input | LVL_W (5) | Priority level of the request |
| mask_we_i | input | 1 | Write enable for the CPU mask register |
| mask_wdata_i | input | MASK_W (16) | New CPU destination mask |
| node_id_i | input | NODE_W (4) | Node number of this module |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| csr_valid_o | output | 1 | First data cycle of the broadcast CSR write |
| csr_addr_o | output | ADDR_W (40) | Broadcast register address |
| csr_data_o | output | DATA_W (64) | Packed mask and level |
| drop_o | output | 1 | One-cycle pulse: request dropped on empty mask |

## Verification
A corrupted state register shows at the ports at once: `bus_req_o` and `csr_valid_o` are decoded straight from it, so a lost or extra state surfaces as a request without a following data cycle, or a data cycle without a grant, in the very next cycle. A stale mask or a wrong pending level does not show until the next data cycle, where the packed word differs from the mask and level the bench expects. A pending entry that is lost or duplicated shows one cycle after the current data cycle, as a missing or surplus bus request.

// File: rtl/intr_bcast_pkg.sv
package intr_bcast_pkg;

    // Sequencer states of the broadcast writer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } ib_state_e;

endpackage

// File: rtl/ibw_level_merge.sv
// Combines the pending entry with a new request: valid if either is valid,
// level is the higher of the valid ones.
module ibw_level_merge #(
    parameter int LVL_W = 5
) (
    input  logic             a_v_i,
    input  logic [LVL_W-1:0] a_lvl_i,
    input  logic             b_v_i,
    input  logic [LVL_W-1:0] b_lvl_i,
    output logic             any_v_o,
    output logic [LVL_W-1:0] lvl_o
);
    always_comb begin
        any_v_o = a_v_i | b_v_i;
        if (a_v_i && b_v_i) begin
            lvl_o = (a_lvl_i > b_lvl_i) ? a_lvl_i : b_lvl_i;
        end else if (a_v_i) begin
            lvl_o = a_lvl_i;
        end else if (b_v_i) begin
            lvl_o = b_lvl_i;
        end else begin
            lvl_o = '0;
        end
    end
endmodule

// File: rtl/ibw_word_pack.sv
// Packs mask (low bits) and level (just above) into the write data word.
module ibw_word_pack #(
    parameter int MASK_W = 16,
    parameter int LVL_W  = 5,
    parameter int DATA_W = 64
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic [LVL_W-1:0]  lvl_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int USED_W = MASK_W + LVL_W;

    generate
        if (DATA_W > USED_W) begin : g_pad
            assign word_o = {{(DATA_W - USED_W){1'b0}}, lvl_i, mask_i};
        end else begin : g_exact
            assign word_o = {lvl_i, mask_i};
        end
    endgenerate
endmodule

// File: rtl/ibw_addr_gen.sv
// Broadcast register address: base plus node number times register stride.
module ibw_addr_gen #(
    parameter int                ADDR_W      = 40,
    parameter int                NODE_W      = 4,
    parameter int                STRIDE_LG2  = 6,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 40'hFF_8800_0000
) (
    input  logic [NODE_W-1:0] node_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] offset;

    assign offset = ADDR_W'(node_i) << STRIDE_LG2;
    assign addr_o = BASE_ADDR + offset;
endmodule

// File: rtl/intr_bcast_writer.sv
module intr_bcast_writer
    import intr_bcast_pkg::*;
#(
    parameter int                MASK_W     = 16,
    parameter int                LVL_W      = 5,
    parameter int                DATA_W     = 64,
    parameter int                ADDR_W     = 40,
    parameter int                NODE_W     = 4,
    parameter int                STRIDE_LG2 = 6,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 40'hFF_8800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_valid_i,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic              mask_we_i,
    input  logic [MASK_W-1:0] mask_wdata_i,
    input  logic [NODE_W-1:0] node_id_i,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              csr_valid_o,
    output logic [ADDR_W-1:0] csr_addr_o,
    output logic [DATA_W-1:0] csr_data_o,
    output logic              drop_o
);

    typedef struct packed {
        ib_state_e         state;
        logic [MASK_W-1:0] mask;
        logic              pend_v;
        logic [LVL_W-1:0]  pend_lvl;
        logic [DATA_W-1:0] word;
        logic              drop;
    } regs_t;

    regs_t r_q, r_d;

    logic              merged_v;
    logic [LVL_W-1:0]  merged_lvl;
    logic [DATA_W-1:0] packed_word;
    logic [ADDR_W-1:0] bcast_addr;

    // Pending entry merged with the incoming request.
    ibw_level_merge #(.LVL_W(LVL_W)) u_merge (
        .a_v_i   (r_q.pend_v),
        .a_lvl_i (r_q.pend_lvl),
        .b_v_i   (irq_valid_i),
        .b_lvl_i (irq_level_i),
        .any_v_o (merged_v),
        .lvl_o   (merged_lvl)
    );

    // Word formed from the mask as stored now (before any same-cycle write).
    ibw_word_pack #(.MASK_W(MASK_W), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_pack (
        .mask_i (r_q.mask),
        .lvl_i  (merged_lvl),
        .word_o (packed_word)
    );

    ibw_addr_gen #(
        .ADDR_W     (ADDR_W),
        .NODE_W     (NODE_W),
        .STRIDE_LG2 (STRIDE_LG2),
        .BASE_ADDR  (BASE_ADDR)
    ) u_addr (
        .node_i (node_id_i),
        .addr_o (bcast_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.drop = 1'b0;

        if (mask_we_i) begin
            r_d.mask = mask_wdata_i;
        end

        case (r_q.state)
            ST_REQ: begin
                // Bus busy with our own request: fold new arrivals into pending.
                if (irq_valid_i) begin
                    r_d.pend_v   = 1'b1;
                    r_d.pend_lvl = merged_lvl;
                end
                if (bus_gnt_i) begin
                    r_d.state = ST_DATA;
                end
            end
            ST_IDLE, ST_DATA: begin
                // Data cycle ends the write, so a new one may be launched here.
                r_d.state = ST_IDLE;
                if (merged_v) begin
                    r_d.pend_v = 1'b0;
                    if (r_q.mask == '0) begin
                        r_d.drop = 1'b1;
                    end else begin
                        r_d.state = ST_REQ;
                        r_d.word  = packed_word;
                    end
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req_o   = (r_q.state == ST_REQ);
    assign csr_valid_o = (r_q.state == ST_DATA);
    assign csr_data_o  = csr_valid_o ? r_q.word : '0;
    assign csr_addr_o  = csr_valid_o ? bcast_addr : '0;
    assign drop_o      = r_q.drop;

endmodule

// File: rtl/intr_bcast_writer_chk.sv
module intr_bcast_writer_chk #(
    parameter int                MASK_W     = 16,
    parameter int                LVL_W      = 5,
    parameter int                DATA_W     = 64,
    parameter int                ADDR_W     = 40,
    parameter int                NODE_W     = 4,
    parameter int                STRIDE_LG2 = 6,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 40'hFF_8800_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NODE_W-1:0] node_id_i,
    input logic              bus_req_o,
    input logic              bus_gnt_i,
    input logic              csr_valid_o,
    input logic [ADDR_W-1:0] csr_addr_o,
    input logic [DATA_W-1:0] csr_data_o,
    input logic              drop_o
);
    localparam int USED_W = MASK_W + LVL_W;

    logic [ADDR_W-1:0] exp_addr;
    assign exp_addr = BASE_ADDR + (ADDR_W'(node_id_i) * ADDR_W'(64'd1 << STRIDE_LG2));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_gnt_i) |=> bus_req_o);

    assert_valid_after_gnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_gnt_i) |=> (csr_valid_o && !bus_req_o));

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_valid_o |=> !csr_valid_o);

    assert_data_format_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csr_valid_o |-> ((csr_data_o >> USED_W) == '0 && csr_data_o[MASK_W-1:0] != '0));

    assert_addr_node_R5: assert property (@(posedge clk) disable iff (!rst_n)
        csr_valid_o |-> (csr_addr_o == exp_addr));

    assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_valid_o |-> (csr_addr_o == '0 && csr_data_o == '0));

    assert_drop_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> (!bus_req_o && !csr_valid_o));

    assert_drop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> !drop_o);

    assert_stray_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req_o && bus_gnt_i) |=> !csr_valid_o);
endmodule

bind intr_bcast_writer intr_bcast_writer_chk #(
    .MASK_W     (MASK_W),
    .LVL_W      (LVL_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NODE_W     (NODE_W),
    .STRIDE_LG2 (STRIDE_LG2),
    .BASE_ADDR  (BASE_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .node_id_i   (node_id_i),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .csr_valid_o (csr_valid_o),
    .csr_addr_o  (csr_addr_o),
    .csr_data_o  (csr_data_o),
    .drop_o      (drop_o)
);

// File: tb/intr_bcast_writer_bench.sv
module intr_bcast_writer_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [39:0] BASE       = 40'hFF_8800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_valid_i = 1'b0;
    logic [4:0]  irq_level_i = '0;
    logic        mask_we_i = 1'b0;
    logic [15:0] mask_wdata_i = '0;
    logic [3:0]  node_id_i = 4'd4;
    logic        bus_req_o;
    logic        bus_gnt_i = 1'b0;
    logic        csr_valid_o;
    logic [39:0] csr_addr_o;
    logic [63:0] csr_data_o;
    logic        drop_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_bcast_writer #(.BASE_ADDR(BASE)) u_intr_bcast_writer (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_valid_i  (irq_valid_i),
        .irq_level_i  (irq_level_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .node_id_i    (node_id_i),
        .bus_req_o    (bus_req_o),
        .bus_gnt_i    (bus_gnt_i),
        .csr_valid_o  (csr_valid_o),
        .csr_addr_o   (csr_addr_o),
        .csr_data_o   (csr_data_o),
        .drop_o       (drop_o)
    );

    function automatic logic [63:0] word_of(input logic [15:0] m, input logic [4:0] l);
        return (64'(l) << 16) | 64'(m);
    endfunction

    function automatic logic [39:0] addr_of(input logic [3:0] n);
        return BASE + 40'(n) * 40'd64;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Bus request is high now: grant one cycle and check the data cycle.
    task automatic grant_and_check(input string tag, input logic [63:0] exp_d, input logic [39:0] exp_a);
        bus_gnt_i = 1'b1;
        tick();
        bus_gnt_i = 1'b0;
        check({tag, " R3 valid"}, 64'(csr_valid_o), 64'd1);
        check({tag, " R3 req low"}, 64'(bus_req_o), 64'd0);
        check({tag, " R4 data"}, csr_data_o, exp_d);
        check({tag, " R5 addr"}, 64'(csr_addr_o), 64'(exp_a));
    endtask

    task automatic post_irq(input logic [4:0] lvl);
        irq_valid_i = 1'b1;
        irq_level_i = lvl;
        tick();
        irq_valid_i = 1'b0;
    endtask

    task automatic write_mask(input logic [15:0] m);
        mask_we_i    = 1'b1;
        mask_wdata_i = m;
        tick();
        mask_we_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 req in reset", 64'(bus_req_o), 64'd0);
        check("R1 valid in reset", 64'(csr_valid_o), 64'd0);
        check("R1 drop in reset", 64'(drop_o), 64'd0);
        rst_n = 1'b1;
        tick();
        post_irq(5'd4);
        check("R1 empty mask drops", 64'(drop_o), 64'd1);
        check("R1 no req", 64'(bus_req_o), 64'd0);
    endtask

    task automatic t_basic();
        write_mask(16'h00A5);
        post_irq(5'd7);
        check("R2 req raised", 64'(bus_req_o), 64'd1);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R2 req held", 64'(bus_req_o), 64'd1);
        end
        grant_and_check("basic", word_of(16'h00A5, 5'd7), addr_of(4'd4));
        tick();
        check("R3 single cycle", 64'(csr_valid_o), 64'd0);
        check("R6 data quiet", csr_data_o, 64'd0);
        check("R6 addr quiet", 64'(csr_addr_o), 64'd0);
        check("R2 req dropped", 64'(bus_req_o), 64'd0);
    endtask

    task automatic t_pending();
        post_irq(5'd3);
        post_irq(5'd9);
        irq_valid_i  = 1'b1;
        irq_level_i  = 5'd5;
        mask_we_i    = 1'b1;
        mask_wdata_i = 16'h0F00;
        tick();
        irq_valid_i = 1'b0;
        mask_we_i   = 1'b0;
        grant_and_check("inflight R4", word_of(16'h00A5, 5'd3), addr_of(4'd4));
        tick();
        check("R7 pending req", 64'(bus_req_o), 64'd1);
        grant_and_check("merged R8", word_of(16'h0F00, 5'd9), addr_of(4'd4));
        tick();
        check("R8 one write only", 64'(bus_req_o), 64'd0);
    endtask

    task automatic t_stray_grant();
        bus_gnt_i = 1'b1;
        tick();
        tick();
        bus_gnt_i = 1'b0;
        check("R10 no valid", 64'(csr_valid_o), 64'd0);
        tick();
        check("R10 still idle", 64'(csr_valid_o | bus_req_o), 64'd0);
    endtask

    task automatic t_same_cycle_mask();
        irq_valid_i  = 1'b1;
        irq_level_i  = 5'd2;
        mask_we_i    = 1'b1;
        mask_wdata_i = 16'h1234;
        tick();
        irq_valid_i = 1'b0;
        mask_we_i   = 1'b0;
        check("R11 req", 64'(bus_req_o), 64'd1);
        grant_and_check("R11 old mask", word_of(16'h0F00, 5'd2), addr_of(4'd4));
        tick();
        post_irq(5'd31);
        grant_and_check("R11 new mask", word_of(16'h1234, 5'd31), addr_of(4'd4));
        tick();
    endtask

    task automatic t_other_node();
        node_id_i = 4'd11;
        tick();
        post_irq(5'd1);
        grant_and_check("R5 node 11", word_of(16'h1234, 5'd1), addr_of(4'd11));
        tick();
        node_id_i = 4'd4;
    endtask

    task automatic t_pending_drop();
        post_irq(5'd6);
        irq_valid_i  = 1'b1;
        irq_level_i  = 5'd1;
        mask_we_i    = 1'b1;
        mask_wdata_i = 16'h0000;
        tick();
        irq_valid_i = 1'b0;
        mask_we_i   = 1'b0;
        grant_and_check("R4 before drop", word_of(16'h1234, 5'd6), addr_of(4'd4));
        tick();
        check("R9 drop pulse", 64'(drop_o), 64'd1);
        check("R9 no req", 64'(bus_req_o), 64'd0);
        tick();
        check("R9 pulse ends", 64'(drop_o), 64'd0);
        check("R9 discarded", 64'(bus_req_o), 64'd0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        t_basic();
        t_pending();
        t_stray_grant();
        t_same_cycle_mask();
        t_other_node();
        t_pending_drop();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule